// File: doc/BRIEF.md
# 8b/10b Line Encoder with Comma Preamble

The block turns one 8-bit character per clock into a 10-bit code group of the standard 8b/10b code. It keeps the running disparity between characters so that the serial stream stays DC balanced. A per-character control flag selects between the data code space (Dx.y) and the control code space (Kx.y). The output register feeds a serializer, which sends bit `a` (bit 0) first.

While the synchronous reset is held, the encoder sends the negative-disparity form of K28.5 on every cycle. When reset is released it starts from negative disparity and sends a fixed preamble of three K28.5 commas, each in the form its disparity calls for. Only then does it raise `ready_o` and start encoding characters. An illegal control request sets an error flag for that code group. The block still emits a defined code group in that case: the data encoding of the same byte.

Top module: `lc_enc8b10b`

## Requirements
- R1: In every cycle after a rising edge at which `rst` was high, `code_o` is 10'h17C (K28.5, negative form, bit 0 = a), `rd_o` is 0, `ready_o` is 0 and `err_o` is 0.
- R2: After reset is released, the next three code groups are K28.5 in the form selected by the current disparity: 10'h17C, then 10'h283, then 10'h17C. `rd_o` toggles after each of them.
- R3: `ready_o` is low during reset and during the first two preamble groups. It rises together with the third preamble group and stays high until the next reset.
- R4: While `ready_o` is low, `char_i` and `ctrl_i` have no effect: the next group is a preamble comma and `err_o` stays low.
- R5: With `ctrl_i` low, a character sampled while `ready_o` is high appears one clock later as its Dx.y code group. Here x = `char_i[4:0]` (EDCBA) and y = `char_i[7:5]` (HGF). The output mapping is `code_o[5:0]` = a,b,c,d,e,i and `code_o[9:6]` = f,g,h,j.
- R6: When the disparity before a group is negative (`rd_o` = 0), that group has five or six ones. When it is positive, the group has four or five ones.
- R7: `rd_o` (1 = positive) toggles exactly when the group just emitted is unbalanced (its count of ones is not five).
- R8: With `ctrl_i` high, K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 are encoded as their control code groups, and `err_o` stays low.
- R9: For y = 7 data, the alternate 3b/4b form is used when the disparity is negative and x is 17, 18 or 20, or when it is positive and x is 11, 13 or 14. All other data with y = 7 uses the primary form.
- R10: With `ctrl_i` high and any other byte, `err_o` is high for that code group, and the group is the data encoding of the same byte.
- R11: The serial stream, taken bit 0 first, never holds more than five equal bits in a row.
- R12: Reset asserted in the middle of a stream, at either disparity, restores the state of R1, and the three-comma preamble repeats after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| char_i | input | 8 | Character to encode, HGF in [7:5], EDCBA in [4:0] |
| ctrl_i | input | 1 | High selects the control code space |
| code_o | output | 10 | Registered code group, bit 0 = a, bit 9 = j |
| rd_o | output | 1 | Running disparity after `code_o`, 1 = positive |
| ready_o | output | 1 | High when the character presented at the next edge will be encoded |
| err_o | output | 1 | High when `code_o` came from an illegal control request |

## Verification
A wrong running disparity shows up as soon as the next unbalanced group leaves in the wrong column. That group then carries the wrong count of ones and breaks the ones-count rule one clock after the bad state, even when no exact code value is known for it. A preamble counter that is off by one shows at the ports as a missing or extra comma and as `ready_o` rising in the wrong cycle. A slip in the alternate-form rule or in the sub-block tables appears only on specific characters. For that reason the exact code groups of those characters are compared in both disparity columns, and a long pseudo-random stream is checked against the ones-count, disparity-tracking and run-length rules.

// File: rtl/lc_enc_pkg.sv
package lc_enc_pkg;

    localparam int CHAR_W = 8;
    localparam int CODE_W = 10;
    localparam int SUB6_W = 6;
    localparam int SUB4_W = 4;

    // K28.5 in both columns, bit 0 = a
    localparam logic [CODE_W-1:0] COMMA_NEG = 10'h17C;
    localparam logic [CODE_W-1:0] COMMA_POS = 10'h283;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              rd;
        logic              err;
    } enc_state_t;

endpackage

// File: rtl/lc_enc_6b.sv
module lc_enc_6b
    import lc_enc_pkg::*;
(
    input  logic [4:0]        x_i,
    input  logic              k28_i,
    input  logic              rd_i,
    output logic [SUB6_W-1:0] sym_o,
    output logic              rd_o
);

    // table entries written with bit a leftmost, negative column
    logic [SUB6_W-1:0] tab_w;
    logic [SUB6_W-1:0] neg_form;
    logic              unbal;
    logic              flip;

    always_comb begin
        case (x_i)
            5'd0:    tab_w = 6'b100111;
            5'd1:    tab_w = 6'b011101;
            5'd2:    tab_w = 6'b101101;
            5'd3:    tab_w = 6'b110001;
            5'd4:    tab_w = 6'b110101;
            5'd5:    tab_w = 6'b101001;
            5'd6:    tab_w = 6'b011001;
            5'd7:    tab_w = 6'b111000;
            5'd8:    tab_w = 6'b111001;
            5'd9:    tab_w = 6'b100101;
            5'd10:   tab_w = 6'b010101;
            5'd11:   tab_w = 6'b110100;
            5'd12:   tab_w = 6'b001101;
            5'd13:   tab_w = 6'b101100;
            5'd14:   tab_w = 6'b011100;
            5'd15:   tab_w = 6'b010111;
            5'd16:   tab_w = 6'b011011;
            5'd17:   tab_w = 6'b100011;
            5'd18:   tab_w = 6'b010011;
            5'd19:   tab_w = 6'b110010;
            5'd20:   tab_w = 6'b001011;
            5'd21:   tab_w = 6'b101010;
            5'd22:   tab_w = 6'b011010;
            5'd23:   tab_w = 6'b111010;
            5'd24:   tab_w = 6'b110011;
            5'd25:   tab_w = 6'b100110;
            5'd26:   tab_w = 6'b010110;
            5'd27:   tab_w = 6'b110110;
            5'd28:   tab_w = 6'b001110;
            5'd29:   tab_w = 6'b101110;
            5'd30:   tab_w = 6'b011110;
            default: tab_w = 6'b101011;
        endcase
        if (k28_i) begin
            tab_w = 6'b001111;
        end
    end

    for (genvar i = 0; i < SUB6_W; i++) begin : g_order
        assign neg_form[i] = tab_w[SUB6_W-1-i];
    end

    assign unbal = ($countones(neg_form) != 3);
    // x = 7 is balanced yet still alternates between columns
    assign flip  = unbal || ((x_i == 5'd7) && !k28_i);
    assign sym_o = (rd_i && flip) ? ~neg_form : neg_form;
    assign rd_o  = rd_i ^ unbal;

endmodule

// File: rtl/lc_enc_4b.sv
module lc_enc_4b
    import lc_enc_pkg::*;
(
    input  logic [2:0]        y_i,
    input  logic [4:0]        x_i,
    input  logic              k_i,
    input  logic              rd_i,
    output logic [SUB4_W-1:0] sym_o,
    output logic              rd_o
);

    logic              alt7;
    logic [SUB4_W-1:0] tab_w;
    logic [SUB4_W-1:0] neg_form;
    logic              unbal;
    logic              flip;

    always_comb begin
        alt7 = 1'b0;
        if (!k_i && (y_i == 3'd7)) begin
            if (!rd_i) begin
                alt7 = (x_i == 5'd17) || (x_i == 5'd18) || (x_i == 5'd20);
            end else begin
                alt7 = (x_i == 5'd11) || (x_i == 5'd13) || (x_i == 5'd14);
            end
        end
    end

    // entries written with bit f leftmost, negative column
    always_comb begin
        if (k_i) begin
            case (y_i)
                3'd0:    tab_w = 4'b1011;
                3'd1:    tab_w = 4'b0110;
                3'd2:    tab_w = 4'b1010;
                3'd3:    tab_w = 4'b1100;
                3'd4:    tab_w = 4'b1101;
                3'd5:    tab_w = 4'b0101;
                3'd6:    tab_w = 4'b1001;
                default: tab_w = 4'b0111;
            endcase
        end else if (alt7) begin
            tab_w = 4'b0111;
        end else begin
            case (y_i)
                3'd0:    tab_w = 4'b1011;
                3'd1:    tab_w = 4'b1001;
                3'd2:    tab_w = 4'b0101;
                3'd3:    tab_w = 4'b1100;
                3'd4:    tab_w = 4'b1101;
                3'd5:    tab_w = 4'b1010;
                3'd6:    tab_w = 4'b0110;
                default: tab_w = 4'b1110;
            endcase
        end
    end

    for (genvar i = 0; i < SUB4_W; i++) begin : g_order
        assign neg_form[i] = tab_w[SUB4_W-1-i];
    end

    assign unbal = ($countones(neg_form) != 2);
    // control groups always take the complement in the positive column
    assign flip  = k_i || unbal || (y_i == 3'd3);
    assign sym_o = (rd_i && flip) ? ~neg_form : neg_form;
    assign rd_o  = rd_i ^ unbal;

endmodule

// File: rtl/lc_kcheck.sv
module lc_kcheck
    import lc_enc_pkg::*;
(
    input  logic [CHAR_W-1:0] char_i,
    input  logic              ctrl_i,
    output logic              k_ok_o,
    output logic              k28_o,
    output logic              k_bad_o
);

    logic [4:0] x;
    logic [2:0] y;
    logic       ext7;
    logic       legal;

    assign x     = char_i[4:0];
    assign y     = char_i[7:5];
    assign k28_o = (x == 5'd28);
    assign ext7  = (y == 3'd7) &&
                   ((x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30));
    assign legal = k28_o || ext7;

    assign k_ok_o  = ctrl_i && legal;
    assign k_bad_o = ctrl_i && !legal;

endmodule

// File: rtl/lc_preamble.sv
module lc_preamble #(
    parameter int PRE_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(PRE_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRE_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != LAST) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.done = (s_d.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.cnt != LAST);
    assign done_o = s_q.done;

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o); // R3

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy_o)); // R3

endmodule

// File: rtl/lc_enc8b10b.sv
module lc_enc8b10b
    import lc_enc_pkg::*;
#(
    parameter int PRE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              ctrl_i,
    output logic [CODE_W-1:0] code_o,
    output logic              rd_o,
    output logic              ready_o,
    output logic              err_o
);

    enc_state_t s_d, s_q;

    logic              pre_busy;
    logic              pre_done;
    logic              k_ok;
    logic              k28;
    logic              k_bad;
    logic [SUB6_W-1:0] sym6;
    logic [SUB4_W-1:0] sym4;
    logic              rd_mid;
    logic              rd_end;

    lc_preamble #(.PRE_LEN(PRE_LEN)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .busy_o (pre_busy),
        .done_o (pre_done)
    );

    lc_kcheck u_kchk (
        .char_i  (char_i),
        .ctrl_i  (ctrl_i),
        .k_ok_o  (k_ok),
        .k28_o   (k28),
        .k_bad_o (k_bad)
    );

    lc_enc_6b u_6b (
        .x_i   (char_i[4:0]),
        .k28_i (k_ok && k28),
        .rd_i  (s_q.rd),
        .sym_o (sym6),
        .rd_o  (rd_mid)
    );

    lc_enc_4b u_4b (
        .y_i   (char_i[7:5]),
        .x_i   (char_i[4:0]),
        .k_i   (k_ok),
        .rd_i  (rd_mid),
        .sym_o (sym4),
        .rd_o  (rd_end)
    );

    always_comb begin
        s_d = s_q;
        if (pre_busy) begin
            s_d.code = s_q.rd ? COMMA_POS : COMMA_NEG;
            s_d.rd   = ~s_q.rd;
            s_d.err  = 1'b0;
        end else begin
            s_d.code = {sym4, sym6};
            s_d.rd   = rd_end;
            s_d.err  = k_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.code <= COMMA_NEG;
            s_q.rd   <= 1'b0;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o  = s_q.code;
    assign rd_o    = s_q.rd;
    assign err_o   = s_q.err;
    assign ready_o = pre_done;

    AST_RESET_COMMA: assert property (@(posedge clk)
        rst |=> (code_o == COMMA_NEG && !rd_o && !ready_o && !err_o)); // R1

    AST_PRE_COMMA: assert property (@(posedge clk) disable iff (rst)
        !ready_o |=> (code_o == COMMA_NEG || code_o == COMMA_POS)); // R2

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        !ready_o |=> !err_o); // R4

    AST_NEG_COLUMN: assert property (@(posedge clk) disable iff (rst)
        !rd_o |=> ($countones(code_o) == 5 || $countones(code_o) == 6)); // R6

    AST_POS_COLUMN: assert property (@(posedge clk) disable iff (rst)
        rd_o |=> ($countones(code_o) == 4 || $countones(code_o) == 5)); // R6

    AST_RD_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rd_o != $past(rd_o)) == ($countones(code_o) != 5))); // R7

    AST_BAD_K_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ready_o && k_bad) |=> err_o); // R10

endmodule

// File: tb/tb_lc_enc8b10b.sv
module tb_lc_enc8b10b;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] char_i = 8'h00;
    logic       ctrl_i = 1'b0;
    wire  [9:0] code_o;
    wire        rd_o;
    wire        ready_o;
    wire        err_o;

    int   n_chk = 0;
    int   n_fail = 0;
    int   m_pre = 3;
    logic m_rd = 1'b0;
    int   run_len = 0;
    logic last_bit = 1'b0;
    bit   run_valid = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lc_enc8b10b dut (
        .clk     (clk),
        .rst     (rst),
        .char_i  (char_i),
        .ctrl_i  (ctrl_i),
        .code_o  (code_o),
        .rd_o    (rd_o),
        .ready_o (ready_o),
        .err_o   (err_o)
    );

    // literals are written a..j left to right; return with a at bit 0
    function automatic logic [9:0] aj(logic [9:0] w);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = w[9-i];
        return r;
    endfunction

    function automatic bit legal_k(logic [7:0] c);
        if (c[4:0] == 5'd28) return 1'b1;
        if (c[7:5] == 3'd7 && (c[4:0] == 5'd23 || c[4:0] == 5'd27 ||
                               c[4:0] == 5'd29 || c[4:0] == 5'd30)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string req, bit ok, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(bit r, logic [7:0] c, bit k, bit has_exp,
                        logic [9:0] exp_n, logic [9:0] exp_p, string tag);
        int ones;
        logic [9:0] e;
        rst = r; char_i = c; ctrl_i = k;
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (r) begin
            chk(tag, code_o == 10'h17C, code_o, 10'h17C);
            chk(tag, rd_o == 1'b0, 10'(rd_o), 10'd0);
            chk(tag, ready_o == 1'b0, 10'(ready_o), 10'd0);
            chk(tag, err_o == 1'b0, 10'(err_o), 10'd0);
            m_pre = 3;
            m_rd = 1'b0;
        end else if (m_pre > 0) begin
            e = m_rd ? 10'h283 : 10'h17C;
            chk("R2", code_o == e, code_o, e);
            m_rd = ~m_rd;
            m_pre--;
            chk("R2", rd_o == m_rd, 10'(rd_o), 10'(m_rd));
            chk("R3", ready_o == (m_pre == 0), 10'(ready_o), 10'(m_pre == 0));
            chk("R4", err_o == 1'b0, 10'(err_o), 10'd0);
        end else begin
            ones = $countones(code_o);
            if (m_rd) chk("R6", ones == 4 || ones == 5, 10'(ones), 10'd4);
            else      chk("R6", ones == 5 || ones == 6, 10'(ones), 10'd6);
            if (has_exp) begin
                e = m_rd ? exp_p : exp_n;
                chk(tag, code_o == e, code_o, e);
            end
            if (ones != 5) m_rd = ~m_rd;
            chk("R7", rd_o == m_rd, 10'(rd_o), 10'(m_rd));
            chk("R3", ready_o == 1'b1, 10'(ready_o), 10'd1);
            chk("R10", err_o == (k && !legal_k(c)), 10'(err_o), 10'(k && !legal_k(c)));
        end
        for (int i = 0; i < 10; i++) begin
            if (run_valid && code_o[i] == last_bit) run_len++;
            else run_len = 1;
            last_bit = code_o[i];
            run_valid = 1'b1;
            if (run_len > 5) break;
        end
        chk("R11", run_len <= 5, 10'(run_len), 10'd5);
    endtask

    task automatic spot(logic [7:0] c, bit k, logic [9:0] n, logic [9:0] p, string tag);
        tick(1'b0, c, k, 1'b1, aj(n), aj(p), tag);
        tick(1'b0, 8'hBC, 1'b1, 1'b1, aj(10'b0011111010), aj(10'b1100000101), "R8");
        tick(1'b0, c, k, 1'b1, aj(n), aj(p), tag);
        tick(1'b0, c, k, 1'b1, aj(n), aj(p), tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [7:0]  c;
        bit          k;
        // R1: reset state
        for (int i = 0; i < 3; i++) tick(1'b1, 8'h00, 1'b0, 1'b0, '0, '0, "R1");
        // R2 R3 R4: preamble with an illegal control request held on the inputs
        for (int i = 0; i < 3; i++) tick(1'b0, 8'h00, 1'b1, 1'b0, '0, '0, "R4");
        // R5: data groups
        spot(8'h00, 1'b0, 10'b1001110100, 10'b0110001011, "R5");
        spot(8'hB5, 1'b0, 10'b1010101010, 10'b1010101010, "R5");
        spot(8'h4A, 1'b0, 10'b0101010101, 10'b0101010101, "R5");
        spot(8'hE7, 1'b0, 10'b1110001110, 10'b0001110001, "R5");
        spot(8'h63, 1'b0, 10'b1100011100, 10'b1100010011, "R5");
        // R9: alternate form selection
        spot(8'hF1, 1'b0, 10'b1000110111, 10'b1000110001, "R9");
        spot(8'hEB, 1'b0, 10'b1101001110, 10'b1101001000, "R9");
        // R8: control groups
        spot(8'hBC, 1'b1, 10'b0011111010, 10'b1100000101, "R8");
        spot(8'hFC, 1'b1, 10'b0011111000, 10'b1100000111, "R8");
        spot(8'hF7, 1'b1, 10'b1110101000, 10'b0001010111, "R8");
        spot(8'h1C, 1'b1, 10'b0011110100, 10'b1100001011, "R8");
        // R10: illegal control requests fall back to the data group
        spot(8'h00, 1'b1, 10'b1001110100, 10'b0110001011, "R10");
        spot(8'hE7, 1'b1, 10'b1110001110, 10'b0001110001, "R10");
        // pseudo-random stream: R6 R7 R10 R11
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = lfsr[7:0];
            k = (lfsr[10:8] == 3'd0);
            if (k && lfsr[11]) c = {lfsr[14:12], 5'd28};
            tick(1'b0, c, k, 1'b0, '0, '0, "R5");
        end
        // R12: reset from positive disparity
        if (!m_rd) tick(1'b0, 8'hBC, 1'b1, 1'b1, aj(10'b0011111010), aj(10'b1100000101), "R8");
        tick(1'b1, 8'h55, 1'b0, 1'b0, '0, '0, "R12");
        tick(1'b1, 8'h55, 1'b0, 1'b0, '0, '0, "R12");
        for (int i = 0; i < 3; i++) tick(1'b0, 8'hFF, 1'b1, 1'b0, '0, '0, "R12");
        spot(8'hB5, 1'b0, 10'b1010101010, 10'b1010101010, "R12");
        spot(8'h00, 1'b0, 10'b1001110100, 10'b0110001011, "R12");
        // R12: reset from negative disparity
        if (m_rd) tick(1'b0, 8'hBC, 1'b1, 1'b1, aj(10'b0011111010), aj(10'b1100000101), "R8");
        tick(1'b1, 8'h00, 1'b0, 1'b0, '0, '0, "R12");
        for (int i = 0; i < 3; i++) tick(1'b0, 8'h00, 1'b0, 1'b0, '0, '0, "R12");
        spot(8'hF1, 1'b0, 10'b1000110111, 10'b1000110001, "R12");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule